// File: doc/BRIEF.md
# Network Board Control/Status Register with Parity Error Capture

This block holds the host-visible 16-bit control and status word of a network interface board, and a pair of registers that record where a memory parity error happened. Through the control word the host resets the board, moves the interface between loopback and live operation, strobes the attention line of the network controller, enables the auxiliary backplane memory bus, and selects the memory device size and the high address bits. The same word reports two event flags. One flag is set by a pulse from the controller. The other flag is raised when the parity checker reports an error.

When a parity error is reported and no earlier error is pending, the block captures the failing 20-bit address. The address is split across two registers: the upper bits go into the parity control word and the lower 16 bits into a separate register. The byte lane and the error source are captured as well. The capture stays frozen until the host writes the acknowledge bit. A single host interrupt request combines both flags with their enables.

Host writes are single-cycle strobes with a 2-bit register select. Reads are combinational from the same kind of select.

Top module: `nic_csr_block`

## Requirements
- R1: After reset, all three registers read zero, and brd_reset, on_air, attn, aux_bus_en, mem_256k, hi_addr and host_irq are all low.
- R2: A write to select 0 with bit 15 clear loads the control fields, which appear on their outputs one cycle later and read back at the same positions:
  - bit 14 drives on_air;
  - bit 13 drives attn, as a level;
  - bit 12 is the interrupt enable;
  - bit 11 is the parity interrupt enable;
  - bit 5 drives aux_bus_en;
  - bit 4 drives mem_256k;
  - bits 3:0 drive hi_addr.
- R3: A write to select 0 with bit 15 set raises brd_reset (status bit 15) and forces every other control field of R2 to zero, whatever the written data.
- R4: The controller interrupt flag (status bit 8) is set by a one-cycle pulse on ctl_irq_pulse. A write to select 0 with bit 8 set clears it. A pulse in the same cycle as such a clear leaves the flag set. Writing 0 to bit 8 leaves the flag unchanged.
- R5: When a parity error pulse arrives and no error is pending, the parity flag (status bit 9) is set. The capture lands as follows:
  - address bits 19:16 go to select 1 bits 3:0;
  - the source goes to select 1 bit 7;
  - the byte lane goes to select 1 bit 6;
  - address bits 15:0 go to select 2.
- R6: While the parity flag is set and no acknowledge is written, further error pulses change neither the flag nor any captured field.
- R7: A write to select 1 with bit 8 set acknowledges the error and clears the parity flag. An error pulse in the acknowledge cycle is captured as a new error, and the flag stays set.
- R8: host_irq is high exactly when (controller flag AND interrupt enable) OR (parity flag AND parity interrupt enable). It follows the register state with no extra delay.
- R9: The following bits always read zero: status bits 10, 7 and 6; select 1 bits 15:8, 5 and 4; all of select 3.
- R10: Writes to select 2 and select 3 have no effect. Writing status bit 9 does not change the parity flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 2 | Write register select (0 status, 1 parity control, 2 parity address) |
| wr_data | input | 16 | Host write data |
| rd_sel | input | 2 | Read register select |
| rd_data | output | 16 | Read data for rd_sel |
| ctl_irq_pulse | input | 1 | One-cycle interrupt event from the network controller |
| par_err_pulse | input | 1 | One-cycle parity error event |
| par_err_addr | input | 20 | Address of the failing access |
| par_err_lane | input | 1 | Byte lane of the failing access |
| par_err_src | input | 1 | Source of the failing access |
| brd_reset | output | 1 | Board reset |
| on_air | output | 1 | Leave loopback and connect to the network |
| attn | output | 1 | Controller attention level |
| aux_bus_en | output | 1 | Auxiliary backplane bus enable |
| mem_256k | output | 1 | Larger memory device select |
| hi_addr | output | 4 | High address bits for board memory |
| host_irq | output | 1 | Combined interrupt request |

## Verification
The hardest situations to reach are collisions in a single cycle. One is an error pulse that arrives in the same cycle as the acknowledge. Another is a controller pulse that meets a write-one-to-clear of its flag. A third is a second error that arrives while a capture is frozen. Random stimulus alone rarely lines these up at the right moment. Directed sequences therefore first build the pending state and then fire both events in the same cycle. A long random phase with heavy pulse rates then mixes these collisions with register writes, and a bench model checks every read select and output after every cycle.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;
    localparam int DATA_W = 16;
    localparam int ERR_ADDR_W = 20;
    localparam int LO_W = 16;
    localparam int HI_W = ERR_ADDR_W - LO_W;

    // status word bit positions
    localparam int B_RST   = 15;
    localparam int B_AIR   = 14;
    localparam int B_ATTN  = 13;
    localparam int B_IEN   = 12;
    localparam int B_PIEN  = 11;
    localparam int B_PFLAG = 9;
    localparam int B_IFLAG = 8;
    localparam int B_AUX   = 5;
    localparam int B_M256  = 4;

    // parity control bit positions
    localparam int B_ACK  = 8;
    localparam int B_SRC  = 7;
    localparam int B_LANE = 6;

    localparam logic [1:0] SEL_STAT  = 2'd0;
    localparam logic [1:0] SEL_PCTL  = 2'd1;
    localparam logic [1:0] SEL_PADDR = 2'd2;

    typedef struct packed {
        logic            rst;
        logic            air;
        logic            attn;
        logic            ien;
        logic            pien;
        logic            aux;
        logic            m256;
        logic [HI_W-1:0] hia;
        logic            iflag;
    } ctrl_t;

    typedef struct packed {
        logic            flag;
        logic            src;
        logic            lane;
        logic [HI_W-1:0] hi;
        logic [LO_W-1:0] lo;
    } par_t;
endpackage

// File: rtl/csr_ctrl.sv
module csr_ctrl
    import nic_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stat,
    input  logic [DATA_W-1:0] wdata,
    input  logic              irq_pulse,
    output ctrl_t             ctrl
);
    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_stat) begin
            if (wdata[B_RST]) begin
                ctrl_d.rst  = 1'b1;
                ctrl_d.air  = 1'b0;
                ctrl_d.attn = 1'b0;
                ctrl_d.ien  = 1'b0;
                ctrl_d.pien = 1'b0;
                ctrl_d.aux  = 1'b0;
                ctrl_d.m256 = 1'b0;
                ctrl_d.hia  = '0;
            end else begin
                ctrl_d.rst  = 1'b0;
                ctrl_d.air  = wdata[B_AIR];
                ctrl_d.attn = wdata[B_ATTN];
                ctrl_d.ien  = wdata[B_IEN];
                ctrl_d.pien = wdata[B_PIEN];
                ctrl_d.aux  = wdata[B_AUX];
                ctrl_d.m256 = wdata[B_M256];
                ctrl_d.hia  = wdata[HI_W-1:0];
            end
            if (wdata[B_IFLAG]) ctrl_d.iflag = 1'b0;
        end
        if (irq_pulse) ctrl_d.iflag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl = ctrl_q;

    p_reset_forces_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && wdata[B_RST]) |=> (ctrl_q.rst && !ctrl_q.air && !ctrl_q.attn &&
            !ctrl_q.ien && !ctrl_q.pien && !ctrl_q.aux && !ctrl_q.m256 && ctrl_q.hia == '0));
    p_pulse_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> ctrl_q.iflag);
    p_flag_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.iflag && !(wr_stat && wdata[B_IFLAG])) |=> ctrl_q.iflag);
endmodule

// File: rtl/par_capture.sv
module par_capture
    import nic_csr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ack,
    input  logic                  err,
    input  logic [ERR_ADDR_W-1:0] err_addr,
    input  logic                  err_lane,
    input  logic                  err_src,
    output par_t                  par
);
    par_t par_d, par_q;
    logic can_take;

    always_comb begin
        par_d    = par_q;
        can_take = !par_q.flag || ack;
        if (can_take && err) begin
            par_d.flag = 1'b1;
            par_d.src  = err_src;
            par_d.lane = err_lane;
            par_d.hi   = err_addr[ERR_ADDR_W-1:LO_W];
            par_d.lo   = err_addr[LO_W-1:0];
        end else if (ack) begin
            par_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) par_q <= '0;
        else        par_q <= par_d;
    end

    assign par = par_q;

    p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !par_q.flag) |=> (par_q.flag && par_q.lo == $past(err_addr[LO_W-1:0])));
    p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (par_q.flag && !ack) |=> ($stable(par_q.lo) && $stable(par_q.hi) && par_q.flag));
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !err) |=> !par_q.flag);
endmodule

// File: rtl/irq_merge.sv
module irq_merge (
    input  logic iflag,
    input  logic ien,
    input  logic pflag,
    input  logic pien,
    output logic irq
);
    logic src_ctl, src_par;

    always_comb begin
        src_ctl = iflag & ien;
        src_par = pflag & pien;
        irq     = src_ctl | src_par;
    end
endmodule

// File: rtl/nic_csr_block.sv
module nic_csr_block
    import nic_csr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [1:0]            wr_sel,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [1:0]            rd_sel,
    output logic [DATA_W-1:0]     rd_data,
    input  logic                  ctl_irq_pulse,
    input  logic                  par_err_pulse,
    input  logic [ERR_ADDR_W-1:0] par_err_addr,
    input  logic                  par_err_lane,
    input  logic                  par_err_src,
    output logic                  brd_reset,
    output logic                  on_air,
    output logic                  attn,
    output logic                  aux_bus_en,
    output logic                  mem_256k,
    output logic [HI_W-1:0]       hi_addr,
    output logic                  host_irq
);
    ctrl_t ctrl;
    par_t  par;
    logic  wr_stat, wr_pctl, ack;
    logic [DATA_W-1:0] stat_word, pctl_word;

    always_comb begin
        wr_stat = wr_en && (wr_sel == SEL_STAT);
        wr_pctl = wr_en && (wr_sel == SEL_PCTL);
        ack     = wr_pctl && wr_data[B_ACK];
    end

    csr_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_stat(wr_stat), .wdata(wr_data),
        .irq_pulse(ctl_irq_pulse), .ctrl(ctrl)
    );

    par_capture u_par (
        .clk(clk), .rst_n(rst_n), .ack(ack), .err(par_err_pulse),
        .err_addr(par_err_addr), .err_lane(par_err_lane), .err_src(par_err_src),
        .par(par)
    );

    irq_merge u_irq (
        .iflag(ctrl.iflag), .ien(ctrl.ien), .pflag(par.flag), .pien(ctrl.pien),
        .irq(host_irq)
    );

    always_comb begin
        stat_word          = '0;
        stat_word[B_RST]   = ctrl.rst;
        stat_word[B_AIR]   = ctrl.air;
        stat_word[B_ATTN]  = ctrl.attn;
        stat_word[B_IEN]   = ctrl.ien;
        stat_word[B_PIEN]  = ctrl.pien;
        stat_word[B_PFLAG] = par.flag;
        stat_word[B_IFLAG] = ctrl.iflag;
        stat_word[B_AUX]   = ctrl.aux;
        stat_word[B_M256]  = ctrl.m256;
        stat_word[HI_W-1:0] = ctrl.hia;

        pctl_word          = '0;
        pctl_word[B_SRC]   = par.src;
        pctl_word[B_LANE]  = par.lane;
        pctl_word[HI_W-1:0] = par.hi;

        case (rd_sel)
            SEL_STAT:  rd_data = stat_word;
            SEL_PCTL:  rd_data = pctl_word;
            SEL_PADDR: rd_data = par.lo;
            default:   rd_data = '0;
        endcase
    end

    assign brd_reset  = ctrl.rst;
    assign on_air     = ctrl.air;
    assign attn       = ctrl.attn;
    assign aux_bus_en = ctrl.aux;
    assign mem_256k   = ctrl.m256;
    assign hi_addr    = ctrl.hia;

    p_irq_has_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> (ctrl.iflag || par.flag));
    p_attn_follows_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !wr_data[B_RST]) |=> (attn == $past(wr_data[B_ATTN])));
    p_pctl_readonly_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == SEL_PCTL) |-> (rd_data[15:8] == 8'h00));
endmodule

// File: tb/test_nic_csr_block.sv
`timescale 1ns/1ps
module test_nic_csr_block;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'h0;
    logic [1:0]  rd_sel = 2'd0;
    logic [15:0] rd_data;
    logic        ctl_irq_pulse = 1'b0;
    logic        par_err_pulse = 1'b0;
    logic [19:0] par_err_addr = 20'h0;
    logic        par_err_lane = 1'b0;
    logic        par_err_src = 1'b0;
    logic        brd_reset, on_air, attn, aux_bus_en, mem_256k, host_irq;
    logic [3:0]  hi_addr;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench model
    logic m_rst, m_air, m_attn, m_ien, m_pien, m_aux, m_m256, m_iflag;
    logic [3:0]  m_hia;
    logic m_pf, m_src, m_lane;
    logic [3:0]  m_hi;
    logic [15:0] m_lo;

    always #2.5 clk = ~clk;

    nic_csr_block i_nic_csr_block (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .ctl_irq_pulse(ctl_irq_pulse),
        .par_err_pulse(par_err_pulse), .par_err_addr(par_err_addr),
        .par_err_lane(par_err_lane), .par_err_src(par_err_src),
        .brd_reset(brd_reset), .on_air(on_air), .attn(attn), .aux_bus_en(aux_bus_en),
        .mem_256k(mem_256k), .hi_addr(hi_addr), .host_irq(host_irq)
    );

    function automatic logic [15:0] exp_read(input logic [1:0] s);
        case (s)
            2'd0: return {m_rst, m_air, m_attn, m_ien, m_pien, 1'b0, m_pf, m_iflag,
                          2'b00, m_aux, m_m256, m_hia};
            2'd1: return {8'h00, m_src, m_lane, 2'b00, m_hi};
            2'd2: return m_lo;
            default: return 16'h0;
        endcase
    endfunction

    function automatic logic exp_irq();
        return (m_iflag & m_ien) | (m_pf & m_pien);
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        {m_rst, m_air, m_attn, m_ien, m_pien, m_aux, m_m256, m_iflag} = '0;
        m_hia = '0; m_pf = 0; m_src = 0; m_lane = 0; m_hi = '0; m_lo = '0;
    endtask

    task automatic model_step();
        logic w0, ack;
        w0  = wr_en && wr_sel == 2'd0;
        ack = wr_en && wr_sel == 2'd1 && wr_data[8];
        if (w0) begin
            if (wr_data[15]) begin
                m_rst = 1; {m_air, m_attn, m_ien, m_pien, m_aux, m_m256} = '0; m_hia = '0;
            end else begin
                m_rst = 0; m_air = wr_data[14]; m_attn = wr_data[13]; m_ien = wr_data[12];
                m_pien = wr_data[11]; m_aux = wr_data[5]; m_m256 = wr_data[4];
                m_hia = wr_data[3:0];
            end
        end
        m_iflag = (m_iflag & !(w0 && wr_data[8])) | ctl_irq_pulse;
        if ((!m_pf || ack) && par_err_pulse) begin
            m_pf = 1; m_src = par_err_src; m_lane = par_err_lane;
            m_hi = par_err_addr[19:16]; m_lo = par_err_addr[15:0];
        end else if (ack) begin
            m_pf = 0;
        end
    endtask

    // check everything visible; called just after a negedge
    task automatic check_all(input string tag);
        chk({tag, " R2 outputs"}, {9'h0, on_air, attn, aux_bus_en, mem_256k, hi_addr},
            {9'h0, m_air, m_attn, m_aux, m_m256, m_hia});
        chk({tag, " R3 brd_reset"}, {15'h0, brd_reset}, {15'h0, m_rst});
        chk({tag, " R8 host_irq"}, {15'h0, host_irq}, {15'h0, exp_irq()});
        for (int s = 0; s < 4; s++) begin
            rd_sel = 2'(s);
            #0.2;
            chk({tag, " R9 readback"}, rd_data, exp_read(2'(s)));
        end
    endtask

    // one cycle: inputs already set at the negedge
    task automatic cycle(input string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        wr_en = 0; ctl_irq_pulse = 0; par_err_pulse = 0;
        check_all(tag);
    endtask

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        wr_en = 1; wr_sel = s; wr_data = d;
    endtask

    task automatic perr(input logic [19:0] a, input logic ln, input logic sr);
        par_err_pulse = 1; par_err_addr = a; par_err_lane = ln; par_err_src = sr;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        check_all("R1 reset");

        // R2 control fields
        wr(2'd0, 16'b0111_1000_0011_1010); cycle("R2 load");
        wr(2'd0, 16'b0010_0000_0000_0101); cycle("R2 attn level");
        // R3 reset forces zero
        wr(2'd0, 16'hFFFF); cycle("R3 reset");
        wr(2'd0, 16'h7A3F); cycle("R3 release");
        // R4 flag set, clear, collision, write0
        ctl_irq_pulse = 1; cycle("R4 set");
        wr(2'd0, 16'h1000); cycle("R4 write0 keeps");
        wr(2'd0, 16'h1100); ctl_irq_pulse = 1; cycle("R4 collision");
        wr(2'd0, 16'h1100); cycle("R4 clear");
        // R5 capture, R6 frozen, R7 ack
        wr(2'd0, 16'h0800);
        perr(20'hA5C3E, 1, 0); cycle("R5 capture");
        perr(20'h1234F, 0, 1); cycle("R6 frozen");
        wr(2'd0, 16'h0A00); cycle("R10 status bit9 write");
        wr(2'd2, 16'hFFFF); cycle("R10 paddr write");
        wr(2'd3, 16'hFFFF); cycle("R10 sel3 write");
        wr(2'd1, 16'h0100); perr(20'h5BEEF, 1, 1); cycle("R7 ack+err");
        wr(2'd1, 16'h00FF); cycle("R7 write without ack");
        wr(2'd1, 16'h0100); cycle("R7 ack");
        perr(20'hFFFFF, 1, 1); cycle("R5 capture all ones");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 2 == 0) wr(2'($urandom), 16'($urandom));
            if ($urandom % 5 == 0) ctl_irq_pulse = 1;
            if ($urandom % 6 == 0) perr(20'($urandom), 1'($urandom), 1'($urandom));
            cycle("random R4 R5 R6 R7 R8");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule